// File: doc/BRIEF.md
# Converter Core Power Sequencer

This block decides, cycle by cycle, whether each of a small set of converter cores may be used. Each core has a manual power-down bit. When a core's bit is cleared, a programmable delay counter runs, and the core is not marked ready until the count is complete. The scan controller next to the block receives a ready flag and a one-cycle abort pulse for each core. It asks for scans through this block, so a scan never starts on a core that is still waking up. A start aimed at a core that is not ready is refused and leaves a sticky error flag.

When every core is manually powered down, the shared voltage reference is reported as off and the converter data path is forced to zero. An automatic power-savings flag can also be set. While it is set, all cores are held not ready. Setting any manual power-down bit clears that flag, so the two modes are never active together. The cores that stay up then run their power-up delay and become ready. Scans never resume by themselves after a power-up. A new start request is always needed.

Top module: `adc_pwr_seq`

## Requirements
- R1: After reset, every ready flag, the power-savings flag, the error flag, the scan start pulse and the reference-off flag are all 0.
- R2: A core is powered when its power-down bit is 0 and the power-savings flag is 0. Its ready flag rises at the D-th rising clock edge at which it is powered, where D is the power-up delay input and D = 0 acts as 1. Losing power restarts the count.
- R3: When a core's power-down bit is 1 at a clock edge, that core's ready flag is 0 after that edge.
- R4: A core's abort output is 1 while its power-down bit is 1 and was 0 at the previous clock edge, so it forms a pulse one cycle wide.
- R5: The reference-off output is 1 exactly when all power-down bits are 1.
- R6: While the reference is off, the data output is all zeros. Otherwise it equals the data input.
- R7: When any power-down bit is 1 at a clock edge, the power-savings flag is 0 after that edge, and a set request made at the same time is ignored.
- R8: While the power-savings flag is 1, all cores lose ready. When the flag is cleared by power-down of one core, the other cores run the full delay of R2 and then become ready.
- R9: A start request whose core mask (bit i selects core i) selects only ready cores produces a scan start pulse one cycle wide in the cycle after the request.
- R10: A start request that selects any core that is not ready produces no scan start and sets the error flag. The error flag stays at 1 until reset.
- R11: A scan start pulse only follows a start request. Power-up alone never produces one.
- R12: A set request raises the power-savings flag after the next edge, and a clear request lowers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_i | input | NUM_CORES | Manual power-down bit for each core |
| pu_delay_i | input | DLY_W | Power-up delay in clocks |
| psm_set_i | input | 1 | Request to set the power-savings flag |
| psm_clr_i | input | 1 | Request to clear the power-savings flag |
| psm_o | output | 1 | Power-savings flag |
| start_req_i | input | 1 | Scan start request (sync or software) |
| start_mask_i | input | NUM_CORES | Cores the requested scan uses |
| scan_start_o | output | 1 | Granted scan start pulse |
| start_err_o | output | 1 | Sticky flag for a refused start |
| core_ready_o | output | NUM_CORES | Core ready to convert |
| abort_o | output | NUM_CORES | Abort pulse for a conversion in progress |
| ref_off_o | output | 1 | Shared reference is powered down |
| conv_data_i | input | DATA_W | Raw converter data |
| conv_data_o | output | DATA_W | Converter data, forced low while the reference is off |

## Verification
The bench counts edges from power-up to check that ready rises on exactly the D-th edge. A counter that is off by one, or that keeps its count from an earlier power-up, would raise ready one edge early or late. The bench powers one core down while the power-savings flag is set. A design that did not clear the flag, or that woke the other cores without the delay, would keep them dark or mark them ready too soon. It also checks the reference-off and zero-data behaviour when all three bits are set and again when one bit is cleared. It sends starts to a core that is down and checks that the error flag stays set, that no scan start appears, and that no start appears by itself after power returns.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;
   // Power-up delay with zero treated as one clock.
   function automatic int unsigned eff_delay(input int unsigned d);
      return (d == 0) ? 1 : d;
   endfunction
endpackage

// File: rtl/adc_core_pwr.sv
module adc_core_pwr #(
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pd_bit,
   input  logic             pwr_on,
   input  logic [DLY_W-1:0] pu_delay,
   output logic             ready,
   output logic             abort
);
   localparam int CW = DLY_W + 1;

   logic [DLY_W-1:0] cnt_q;
   logic             ready_q;
   logic             pd_q;
   logic [CW-1:0]    cnt_next;
   logic             reached;

   assign cnt_next = {1'b0, cnt_q} + CW'(1);
   assign reached  = (cnt_next >= {1'b0, pu_delay});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         ready_q <= 1'b0;
         pd_q    <= 1'b0;
      end else begin
         pd_q <= pd_bit;
         if (!pwr_on) begin
            cnt_q   <= '0;
            ready_q <= 1'b0;
         end else if (!ready_q) begin
            if (reached) ready_q <= 1'b1;
            else         cnt_q   <= cnt_next[DLY_W-1:0];
         end
      end
   end

   assign ready = ready_q;
   assign abort = pd_bit & ~pd_q;
endmodule

// File: rtl/adc_scan_gate.sv
module adc_scan_gate #(
   parameter int NUM_CORES = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req,
   input  logic [NUM_CORES-1:0] mask,
   input  logic [NUM_CORES-1:0] ready,
   output logic                 start,
   output logic                 err
);
   logic ok;
   logic start_q;
   logic err_q;

   assign ok = &(ready | ~mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         start_q <= req & ok;
         if (req && !ok) err_q <= 1'b1;
      end
   end

   assign start = start_q;
   assign err   = err_q;
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq #(
   parameter int NUM_CORES = 3,
   parameter int DLY_W     = 8,
   parameter int DATA_W    = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CORES-1:0] pd_i,
   input  logic [DLY_W-1:0]     pu_delay_i,
   input  logic                 psm_set_i,
   input  logic                 psm_clr_i,
   output logic                 psm_o,
   input  logic                 start_req_i,
   input  logic [NUM_CORES-1:0] start_mask_i,
   output logic                 scan_start_o,
   output logic                 start_err_o,
   output logic [NUM_CORES-1:0] core_ready_o,
   output logic [NUM_CORES-1:0] abort_o,
   output logic                 ref_off_o,
   input  logic [DATA_W-1:0]    conv_data_i,
   output logic [DATA_W-1:0]    conv_data_o
);
   initial begin
      assert (NUM_CORES >= 1 && NUM_CORES <= 8)
         else $error("NUM_CORES out of range");
      assert (DLY_W >= 4 && DLY_W <= 16)
         else $error("DLY_W out of range");
      assert (DATA_W >= 1) else $error("DATA_W must be positive");
   end

   logic psm_q;
   logic any_pd;

   assign any_pd = |pd_i;

   // Manual power-down always wins over the power-savings flag.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         psm_q <= 1'b0;
      else if (any_pd)    psm_q <= 1'b0;
      else if (psm_clr_i) psm_q <= 1'b0;
      else if (psm_set_i) psm_q <= 1'b1;
   end
   assign psm_o = psm_q;

   for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
      adc_core_pwr #(.DLY_W(DLY_W)) u_core (
         .clk      (clk),
         .rst_n    (rst_n),
         .pd_bit   (pd_i[g]),
         .pwr_on   (~pd_i[g] & ~psm_q),
         .pu_delay (pu_delay_i),
         .ready    (core_ready_o[g]),
         .abort    (abort_o[g])
      );
   end

   adc_scan_gate #(.NUM_CORES(NUM_CORES)) u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (start_req_i),
      .mask  (start_mask_i),
      .ready (core_ready_o),
      .start (scan_start_o),
      .err   (start_err_o)
   );

   assign ref_off_o   = &pd_i;
   assign conv_data_o = ref_off_o ? '0 : conv_data_i;
endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk #(
   parameter int NUM_CORES = 3,
   parameter int DATA_W    = 12
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_CORES-1:0] pd_i,
   input logic                 psm_o,
   input logic                 start_req_i,
   input logic                 scan_start_o,
   input logic                 start_err_o,
   input logic [NUM_CORES-1:0] core_ready_o,
   input logic                 ref_off_o,
   input logic [DATA_W-1:0]    conv_data_o
);
   // R6: data low whenever the reference is off
   a_r6_data_low: assert property (@(posedge clk) disable iff (!rst_n)
      ref_off_o |-> (conv_data_o == '0));

   // R7: manual power-down clears power savings
   a_r7_psm_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (|pd_i) |=> !psm_o);

   // R11: no start pulse without a request
   a_r11_start_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      scan_start_o |-> $past(start_req_i));

   // R10: error flag is sticky
   a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      start_err_o |=> start_err_o);

   for (genvar g = 0; g < NUM_CORES; g++) begin : g_chk
      // R3: power-down drops ready
      a_r3_pd_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
         pd_i[g] |=> !core_ready_o[g]);
      // R2: ready only rises after a powered cycle
      a_r2_ready_powered: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(core_ready_o[g]) |-> $past(!pd_i[g] && !psm_o));
   end
endmodule

bind adc_pwr_seq adc_pwr_seq_chk #(.NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pd_i         (pd_i),
   .psm_o        (psm_o),
   .start_req_i  (start_req_i),
   .scan_start_o (scan_start_o),
   .start_err_o  (start_err_o),
   .core_ready_o (core_ready_o),
   .ref_off_o    (ref_off_o),
   .conv_data_o  (conv_data_o)
);

// File: tb/adc_pwr_seq_bench.sv
module adc_pwr_seq_bench;
   localparam int N  = 3;
   localparam int DW = 8;
   localparam int XW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pd_i = '0;
   logic [DW-1:0] pu_delay_i = 8'd5;
   logic          psm_set_i = 1'b0;
   logic          psm_clr_i = 1'b0;
   logic          psm_o;
   logic          start_req_i = 1'b0;
   logic [N-1:0]  start_mask_i = '0;
   logic          scan_start_o;
   logic          start_err_o;
   logic [N-1:0]  core_ready_o;
   logic [N-1:0]  abort_o;
   logic          ref_off_o;
   logic [XW-1:0] conv_data_i = 12'hABC;
   logic [XW-1:0] conv_data_o;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   adc_pwr_seq #(.NUM_CORES(N), .DLY_W(DW), .DATA_W(XW)) u_adc_pwr_seq (.*);

   task automatic check(input logic ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Advance n clock edges, returning at the falling edge.
   task automatic edges(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      check(core_ready_o == 0 && psm_o == 0 && start_err_o == 0 && scan_start_o == 0
            && ref_off_o == 0, "R1", {core_ready_o, psm_o, start_err_o, scan_start_o, ref_off_o}, 0);
      edges(4);
      check(core_ready_o == 3'b000, "R2 early", core_ready_o, 0);
      edges(1);
      check(core_ready_o == 3'b111, "R2 on time", core_ready_o, 7);
   endtask

   task automatic t_scan_ok;
      start_req_i = 1'b1; start_mask_i = 3'b011;
      edges(1);
      start_req_i = 1'b0;
      check(scan_start_o == 1'b1, "R9", scan_start_o, 1);
      edges(1);
      check(scan_start_o == 1'b0, "R11 single pulse", scan_start_o, 0);
   endtask

   task automatic t_pd_abort;
      pd_i = 3'b001;
      #1;
      check(abort_o == 3'b001, "R4 pulse", abort_o, 1);
      edges(1);
      check(abort_o == 3'b000, "R4 width", abort_o, 0);
      check(core_ready_o == 3'b110, "R3", core_ready_o, 6);
      check(ref_off_o == 1'b0, "R5 partial", ref_off_o, 0);
   endtask

   task automatic t_blocked;
      start_req_i = 1'b1; start_mask_i = 3'b001;
      edges(1);
      start_req_i = 1'b0;
      check(scan_start_o == 1'b0, "R10 no start", scan_start_o, 0);
      check(start_err_o == 1'b1, "R10 err", start_err_o, 1);
      edges(3);
      check(start_err_o == 1'b1, "R10 sticky", start_err_o, 1);
   endtask

   task automatic t_ref;
      pd_i = 3'b111;
      #1;
      check(ref_off_o == 1'b1, "R5 all", ref_off_o, 1);
      check(conv_data_o == 0, "R6 forced", conv_data_o, 0);
      edges(1);
      pd_i = 3'b011;
      #1;
      check(ref_off_o == 1'b0, "R5 release", ref_off_o, 0);
      check(conv_data_o == 12'hABC, "R6 pass", conv_data_o, 12'hABC);
      edges(1);
   endtask

   task automatic t_repower;
      int starts = 0;
      pu_delay_i = 8'd3;
      pd_i = 3'b000;
      for (int i = 0; i < 2; i++) begin
         edges(1);
         starts += scan_start_o;
      end
      check(core_ready_o[1:0] == 2'b00, "R2 restart early", core_ready_o, 0);
      edges(1);
      starts += scan_start_o;
      check(core_ready_o == 3'b111, "R2 restart", core_ready_o, 7);
      edges(2);
      starts += scan_start_o;
      check(starts == 0, "R11 no resume", starts, 0);
   endtask

   task automatic t_psm;
      psm_set_i = 1'b1;
      edges(1);
      psm_set_i = 1'b0;
      check(psm_o == 1'b1, "R12 set", psm_o, 1);
      edges(1);
      check(core_ready_o == 3'b000, "R8 held", core_ready_o, 0);
      pd_i = 3'b010;
      edges(1);
      check(psm_o == 1'b0, "R7 clear", psm_o, 0);
      edges(2);
      check(core_ready_o == 3'b000, "R8 delay", core_ready_o, 0);
      edges(1);
      check(core_ready_o == 3'b101, "R8 wake", core_ready_o, 5);
      psm_set_i = 1'b1;
      edges(1);
      psm_set_i = 1'b0;
      check(psm_o == 1'b0, "R7 ignored", psm_o, 0);
      pd_i = 3'b000;
      psm_set_i = 1'b1;
      edges(1);
      psm_set_i = 1'b0;
      psm_clr_i = 1'b1;
      edges(1);
      psm_clr_i = 1'b0;
      check(psm_o == 1'b0, "R12 clear", psm_o, 0);
   endtask

   initial begin
      #100000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      edges(2);
      rst_n = 1'b1;
      t_reset();
      t_scan_ok();
      t_pd_abort();
      t_blocked();
      t_ref();
      t_repower();
      t_psm();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule